// File: doc/BRIEF.md
# Address-Sequence Recall Controller

This block watches the address bus of an SRAM during chip-enable-qualified read cycles. It waits for a fixed series of six read addresses. When the sixth address arrives in order, it starts a recall. A recall first clears every word of the working SRAM array and then copies a shadow nonvolatile array into it, word by word. During the whole recall, which lasts a programmable number of clock cycles, the memory is reported busy. The unlock series uses the same kind of ordinary reads as a software store trigger. Every read in the series is a normal read that returns array data, so the controller only observes the bus and never stalls it.

The controller drives two strobes and a word index toward the array. The clear strobe zeroes the indexed SRAM word. The copy strobe loads the indexed SRAM word from the shadow word. Nothing the controller drives can write the shadow array, so a recall leaves the nonvolatile contents unchanged and can be repeated any number of times.

The design has two state machines. The matcher holds a step number from 0 to 5, which is the number of unlock addresses seen so far. The sequencer has four states: `ST_IDLE`, `ST_CLEAR`, `ST_SETTLE` and `ST_COPY`. Its transitions are:
- `ST_IDLE` goes to `ST_CLEAR` on a match.
- `ST_CLEAR` goes to `ST_SETTLE` after the last cleared word. If the settle length is zero, it goes straight to `ST_COPY`.
- `ST_SETTLE` goes to `ST_COPY` when its wait count runs out.
- `ST_COPY` goes back to `ST_IDLE` after the last copied word.

Top module: `recall_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `clr_stb` and `cpy_stb` are 0 and `ready` is 1.
- R2: The unlock series is six reads, each with `ce`=1 and `rd`=1 in one cycle, at these addresses in this order: 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0C63. `busy` rises in the cycle after the clock edge that samples the sixth read.
- R3: A recall first asserts `clr_stb` for DEPTH cycles with `arr_idx` running 0, 1, … DEPTH-1. No `cpy_stb` appears before the last clear.
- R4: After the clear phase and a wait of RECALL_CYC-2·DEPTH cycles, `cpy_stb` is asserted for DEPTH cycles with `arr_idx` running 0 … DEPTH-1. `busy` stays high for exactly RECALL_CYC cycles and falls right after the last copy cycle.
- R5: `ready` is the inverse of `busy` in every cycle.
- R6: A qualified read that does not match the expected next address sends the matcher back to step 0. If that address is 0x0E38, the matcher counts it as step 1.
- R7: A cycle with `ce`=1 and `wr`=1 returns the matcher to step 0.
- R8: Accesses made while `busy` is 1 are ignored and leave the matcher at step 0.
- R9: While `lowv` is 1, the matcher is held at step 0 and no recall can start.
- R10: Cycles with `ce`=0 neither advance nor break the series.
- R11: A recall may be repeated without limit. Each repeat performs a complete clear and then a complete copy of the current shadow contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Chip enable qualifying the access in this cycle |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | ADDR_W | Access address |
| lowv | input | 1 | Low-supply flag; blocks the unlock matcher |
| busy | output | 1 | Recall in progress |
| ready | output | 1 | Array available for normal access |
| clr_stb | output | 1 | Clear the SRAM word at `arr_idx` |
| cpy_stb | output | 1 | Copy the shadow word at `arr_idx` into SRAM |
| arr_idx | output | IDX_W | Word index for the strobes |

## Verification
Each bench access drives the bus on a falling edge, and the rising edge in the middle of that cycle samples it. The falling edge that follows is therefore the first point at which `busy` may show the result of the sixth read, and the bench checks it there. From that edge the bench counts `busy` on falling edges until it drops, and compares the count with RECALL_CYC. A bench model of the array applies the strobes on rising edges, one word per cycle. This model checks the index order and the clear-before-copy order. Once `busy` is low, the bench compares the model's SRAM with the shadow contents. Negative cases are judged at the same falling edge and for a few cycles after it.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SETTLE,
        ST_COPY
    } rsc_state_e;

    localparam int unsigned SEQ_LEN = 6;

    // Unlock address expected at a given matcher step.
    function automatic logic [14:0] seq_code(input logic [2:0] step);
        case (step)
            3'd0:    return 15'h0E38;
            3'd1:    return 15'h31C7;
            3'd2:    return 15'h03E0;
            3'd3:    return 15'h3C1F;
            3'd4:    return 15'h303F;
            3'd5:    return 15'h0C63;
            default: return 15'h0000;
        endcase
    endfunction

endpackage

// File: rtl/rsc_matcher.sv
module rsc_matcher #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ce,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              fire
);
    import rsc_pkg::*;

    localparam logic [2:0] LAST_STEP = 3'(SEQ_LEN - 1);

    logic [2:0] step_q;
    logic [2:0] step_d;
    logic       hit_next;
    logic       hit_first;

    always_comb begin
        hit_next  = (addr == ADDR_W'(seq_code(step_q)));
        hit_first = (addr == ADDR_W'(seq_code(3'd0)));
    end

    // R6 R7 R8 R9 R10: next-step decision
    always_comb begin
        step_d = step_q;
        fire   = 1'b0;
        if (!en) begin
            step_d = 3'd0;
        end else if (ce && wr) begin
            step_d = 3'd0;
        end else if (ce && rd) begin
            if (hit_next) begin
                if (step_q == LAST_STEP) begin
                    fire   = 1'b1;
                    step_d = 3'd0;
                end else begin
                    step_d = step_q + 3'd1;
                end
            end else if (hit_first) begin
                step_d = 3'd1;
            end else begin
                step_d = 3'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= 3'd0;
        else        step_q <= step_d;
    end

endmodule

// File: rtl/rsc_sequencer.sv
module rsc_sequencer #(
    parameter int DEPTH  = 16,
    parameter int SETTLE = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output rsc_pkg::rsc_state_e   state,
    output logic [IDX_W-1:0]      idx
);
    import rsc_pkg::*;

    localparam int CNT_MAX = (DEPTH > SETTLE) ? DEPTH : SETTLE;
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CNT_W-1:0] WORD_LAST   = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = (SETTLE > 0) ? CNT_W'(SETTLE - 1) : '0;

    rsc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    rsc_state_e       after_clear;

    // Parameter picks whether the wait state is visited at all.
    generate
        if (SETTLE > 0) begin : g_with_settle
            assign after_clear = ST_SETTLE;
        end else begin : g_no_settle
            assign after_clear = ST_COPY;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start) state_d = ST_CLEAR;
            end
            ST_CLEAR: begin
                if (cnt_q == WORD_LAST) begin
                    state_d = after_clear;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == SETTLE_LAST) begin
                    state_d = ST_COPY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_COPY: begin
                if (cnt_q == WORD_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state = state_q;
    assign idx   = cnt_q[IDX_W-1:0];

endmodule

// File: rtl/recall_seq_ctrl.sv
module recall_seq_ctrl #(
    parameter int ADDR_W     = 15,
    parameter int DEPTH      = 16,
    parameter int RECALL_CYC = 40,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lowv,
    output logic              busy,
    output logic              ready,
    output logic              clr_stb,
    output logic              cpy_stb,
    output logic [IDX_W-1:0]  arr_idx
);
    import rsc_pkg::*;

    localparam int SETTLE = (RECALL_CYC > 2 * DEPTH) ? RECALL_CYC - 2 * DEPTH : 0;

    rsc_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             fire;
    logic             match_en;

    assign match_en = (state == ST_IDLE) && !lowv;

    rsc_matcher #(
        .ADDR_W (ADDR_W)
    ) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (match_en),
        .ce    (ce),
        .rd    (rd),
        .wr    (wr),
        .addr  (addr),
        .fire  (fire)
    );

    rsc_sequencer #(
        .DEPTH  (DEPTH),
        .SETTLE (SETTLE)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (fire),
        .state (state),
        .idx   (idx)
    );

    // R1 R3 R4 R5: outputs decoded from the registered state
    always_comb begin
        busy    = 1'b1;
        ready   = 1'b0;
        clr_stb = 1'b0;
        cpy_stb = 1'b0;
        arr_idx = idx;
        unique case (state)
            ST_IDLE: begin
                busy  = 1'b0;
                ready = 1'b1;
            end
            ST_CLEAR:  clr_stb = 1'b1;
            ST_SETTLE: ;
            ST_COPY:   cpy_stb = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
    parameter int DEPTH      = 16,
    parameter int RECALL_CYC = 40,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             clr_stb,
    input logic             cpy_stb,
    input logic [IDX_W-1:0] arr_idx
);
    localparam int SETTLE = (RECALL_CYC > 2 * DEPTH) ? RECALL_CYC - 2 * DEPTH : 0;
    localparam int TOTAL  = 2 * DEPTH + SETTLE;

    int unsigned busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (clr_stb && arr_idx == '0));

    a_r3_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_stb && cpy_stb));

    a_r3_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb || cpy_stb) |-> busy);

    a_r3_clear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && $past(clr_stb)) |-> (arr_idx == IDX_W'($past(arr_idx) + 1'b1)));

    a_r4_copy_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cpy_stb && $past(cpy_stb)) |-> (arr_idx == IDX_W'($past(arr_idx) + 1'b1)));

    a_r4_end_on_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cpy_stb) && $past(arr_idx) == IDX_W'(DEPTH - 1)));

    a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == TOTAL));

endmodule

bind recall_seq_ctrl rsc_checker #(
    .DEPTH      (DEPTH),
    .RECALL_CYC (RECALL_CYC)
) u_chk (.*);

// File: tb/sim_recall_seq_ctrl.sv
module sim_recall_seq_ctrl;

    localparam int ADDR_W     = 15;
    localparam int DEPTH      = 8;
    localparam int RECALL_CYC = 24;
    localparam int IDX_W      = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce = 1'b0, rd = 1'b0, wr = 1'b0, lowv = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              busy, ready, clr_stb, cpy_stb;
    logic [IDX_W-1:0]  arr_idx;

    int nchk  = 0;
    int nfail = 0;

    logic [14:0] seq [6];
    logic [7:0]  sram [DEPTH];
    logic [7:0]  nv   [DEPTH];
    int          clr_cnt, cpy_cnt;
    bit          order_bad;

    always #2 clk = ~clk;

    recall_seq_ctrl #(
        .ADDR_W     (ADDR_W),
        .DEPTH      (DEPTH),
        .RECALL_CYC (RECALL_CYC)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .rd      (rd),
        .wr      (wr),
        .addr    (addr),
        .lowv    (lowv),
        .busy    (busy),
        .ready   (ready),
        .clr_stb (clr_stb),
        .cpy_stb (cpy_stb),
        .arr_idx (arr_idx)
    );

    // Behavioural array model driven by the strobes.
    always @(posedge clk) begin
        if (clr_stb) begin
            if (cpy_cnt != 0 || int'(arr_idx) != clr_cnt) order_bad = 1'b1;
            sram[arr_idx] = 8'h00;
            clr_cnt++;
        end
        if (cpy_stb) begin
            if (clr_cnt != DEPTH || sram[arr_idx] != 8'h00 || int'(arr_idx) != cpy_cnt)
                order_bad = 1'b1;
            sram[arr_idx] = nv[arr_idx];
            cpy_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic access(input logic [14:0] a, input bit r, input bit w, input bit c);
        @(negedge clk);
        ce = c; rd = r; wr = w; addr = ADDR_W'(a);
        @(negedge clk);
        ce = 1'b0; rd = 1'b0; wr = 1'b0;
    endtask

    task automatic prep(input int seed);
        for (int i = 0; i < DEPTH; i++) begin
            sram[i] = 8'(8'hA5 ^ i);
            nv[i]   = 8'(seed * 37 + i * 11 + 1);
        end
        clr_cnt = 0; cpy_cnt = 0; order_bad = 1'b0;
    endtask

    task automatic send_seq(input int from, input int upto);
        for (int i = from; i <= upto; i++) access(seq[i], 1'b1, 1'b0, 1'b1);
    endtask

    // Called at the falling edge right after the last access.
    task automatic expect_recall(input bit exp, input string req);
        chk(busy == exp, {req, " busy after sixth read"}, busy, exp);
        if (exp) begin
            int n = 0;
            chk(ready == 1'b0, "R5 ready low while busy", ready, 0);
            while (busy === 1'b1 && n < 1000) begin
                n++;
                @(negedge clk);
            end
            chk(n == RECALL_CYC, "R4 busy length", n, RECALL_CYC);
            chk(ready == 1'b1, "R5 ready high after recall", ready, 1);
            chk(!order_bad && clr_cnt == DEPTH, "R3 clear before copy", clr_cnt, DEPTH);
            chk(cpy_cnt == DEPTH, "R4 copy count", cpy_cnt, DEPTH);
            for (int i = 0; i < DEPTH; i++)
                chk(sram[i] == nv[i], "R11 sram equals shadow", sram[i], nv[i]);
        end else begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(busy == 1'b0, {req, " no recall"}, busy, 0);
            end
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        seq[0] = 15'h0E38; seq[1] = 15'h31C7; seq[2] = 15'h03E0;
        seq[3] = 15'h3C1F; seq[4] = 15'h303F; seq[5] = 15'h0C63;
        prep(0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy at reset", busy, 0);
        chk(ready == 1'b1, "R1 ready at reset", ready, 1);
        chk(clr_stb == 1'b0 && cpy_stb == 1'b0, "R1 strobes at reset", clr_stb, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R11: repeated recalls with fresh shadow data
        for (int s = 1; s <= 3; s++) begin
            prep(s);
            send_seq(0, 5);
            expect_recall(1'b1, "R2");
        end

        // R6: wrong address at each position
        for (int k = 0; k < 6; k++) begin
            prep(10 + k);
            for (int i = 0; i < 6; i++)
                access((i == k) ? 15'h1234 : seq[i], 1'b1, 1'b0, 1'b1);
            expect_recall(1'b0, "R6 broken series");
        end

        // R6: restart on 0x0E38 mid-series
        prep(20);
        send_seq(0, 1);
        send_seq(0, 5);
        expect_recall(1'b1, "R6 restart via first code");
        prep(21);
        send_seq(0, 0);
        send_seq(0, 5);
        expect_recall(1'b1, "R6 doubled first code");

        // R7: write after k reads aborts
        for (int k = 1; k < 6; k++) begin
            prep(30 + k);
            send_seq(0, k - 1);
            access(seq[k], 1'b0, 1'b1, 1'b1);
            send_seq(k, 5);
            expect_recall(1'b0, "R7 write abort");
        end

        // R8: accesses while busy are ignored
        prep(40);
        send_seq(0, 5);
        send_seq(0, 2);
        while (busy === 1'b1) @(negedge clk);
        send_seq(3, 5);
        expect_recall(1'b0, "R8 busy accesses ignored");

        // R9: low-voltage pulse after k reads
        for (int k = 1; k < 6; k++) begin
            prep(50 + k);
            send_seq(0, k - 1);
            @(negedge clk); lowv = 1'b1;
            @(negedge clk); lowv = 1'b0;
            send_seq(k, 5);
            expect_recall(1'b0, "R9 lowv resets matcher");
        end
        prep(60);
        send_seq(0, 4);
        lowv = 1'b1;
        access(seq[5], 1'b1, 1'b0, 1'b1);
        lowv = 1'b0;
        expect_recall(1'b0, "R9 lowv blocks start");

        // R10: unqualified cycles interleaved
        prep(70);
        for (int i = 0; i < 6; i++) begin
            access(15'h7FFF, 1'b1, 1'b0, 1'b0);
            access(15'h0000, 1'b0, 1'b1, 1'b0);
            access(seq[i], 1'b1, 1'b0, 1'b1);
        end
        expect_recall(1'b1, "R10 ce low ignored");

        finish_run();
    end

endmodule